// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that software keeps alive through a small memory-mapped register interface. It does not count on its own. It compares a free-running 64-bit system counter, supplied from outside, against an absolute deadline that it holds internally. When software misses the first deadline, the block raises an alert line, which is meant to drive an interrupt, and arms a second deadline of the same length. If that second deadline also passes without a refresh, the block raises a reset line. Software therefore has one offset period to react to the alert, and the total time from the last refresh to reset is twice the offset.

Two register frames share one simple read/write bus. Each frame has its own select. The refresh frame holds a write-anything keep-alive register. The control frame holds four things:
- the enable and status word,
- the period (offset) register,
- the 64-bit deadline, which can be read,
- an identification word.

Any write to the enable/status word counts as a refresh. A write to the offset register also counts as a refresh, but only while the watchdog is enabled. A warm reset input clears everything except the second-stage flag, so that after the reset it caused, software can still see that the watchdog fired.

Top module: `twostage_wdog`

## Requirements
- R1: After power-on reset these all read zero: the status word (bit 0 enable, bit 1 stage-one flag, bit 2 stage-two flag), the offset register and the deadline. `alertOut` and `resetOut` are low.
- R2: A bus write of any data to address 0x000 of the refresh frame is a refresh. On the following edge, the deadline becomes the counter plus the zero-extended offset, and both stage flags clear.
- R3: A write to control-frame address 0x000 sets enable from data bit 0 and is always a refresh. Data bits 1 and 2 of that write have no effect on the stage flags.
- R4: A write to control-frame address 0x008 stores the 32-bit offset. It is a refresh only when enable is 1, and that refresh uses the newly written offset. While disabled it leaves the deadline unchanged.
- R5: When enable is 1, the counter is at or past the deadline and the stage-one flag is clear, the stage-one flag sets, `alertOut` rises, and the deadline reloads to the counter plus the offset.
- R6: When enable is 1, the counter is at or past the deadline and the stage-one flag is already set, the stage-two flag and `resetOut` set. They stay set until a refresh or a reset that clears them.
- R7: While enable is 0, neither flag sets and the deadline does not move, whatever the counter does.
- R8: The deadline reads at control-frame address 0x010 (bits 31:0) and 0x014 (bits 63:32).
- R9: Address 0xFCC returns the identification parameter in both frames.
- R10: Warm reset clears enable, the stage-one flag, the offset and the deadline, but keeps the stage-two flag and `resetOut`. Power-on reset clears everything.
- R11: A read of any unmapped address in either frame returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| warmRstN | input | 1 | Warm reset, asynchronous, active low; keeps the stage-two flag |
| sysCount | input | 64 | Free-running system counter value |
| busSelRefresh | input | 1 | Select for the refresh frame |
| busSelControl | input | 1 | Select for the control frame |
| busEnable | input | 1 | Access phase qualifier |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset within the selected frame |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the selected frame |
| alertOut | output | 1 | Stage-one alert (interrupt request) |
| resetOut | output | 1 | Stage-two reset request |

## Verification
The state that is hardest to reach is the second stage: the stage-two flag set, then seen to survive a warm reset while everything around it clears. The bench drives the system counter directly as a port instead of letting it run. This lets it place the counter exactly on each deadline in turn, so both expiries fire on chosen edges. It then pulses warm reset and reads the status word back before applying power-on reset. Stepping the counter from the bench also checks the boundary where the counter equals the deadline exactly. It shows that an offset write counts as a refresh only while enabled, by reading the deadline back after each write.

// File: rtl/twostage_wdog_pkg.sv
package twostage_wdog_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 64;

  localparam logic [ADDR_W-1:0] A_CSR    = 12'h000;
  localparam logic [ADDR_W-1:0] A_OFFSET = 12'h008;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h010;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h014;
  localparam logic [ADDR_W-1:0] A_IDENT  = 12'hFCC;

  typedef struct packed {
    logic refresh;
    logic loadOffset;
    logic reload;
  } strobe_t;
endpackage

// File: rtl/twostage_wdog_dpath.sv
module twostage_wdog_dpath
  import twostage_wdog_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] sysCount,
  input  logic [DW-1:0] wdata,
  input  strobe_t       strb,
  output logic [DW-1:0] offsetReg,
  output logic [CW-1:0] compareReg,
  output logic          hit
);
  logic [DW-1:0] offNext;

  assign offNext = strb.loadOffset ? wdata : offsetReg;
  assign hit     = (sysCount >= compareReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetReg  <= '0;
      compareReg <= '0;
    end else begin
      offsetReg <= offNext;
      if (strb.refresh || strb.reload)
        compareReg <= sysCount + {{(CW-DW){1'b0}}, offNext};
    end
  end

  assert_offset_store_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOffset |=> offsetReg == $past(wdata));

  assert_deadline_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.refresh && !strb.reload |=> $stable(compareReg));
endmodule

// File: rtl/twostage_wdog_ctrl.sv
module twostage_wdog_ctrl
  import twostage_wdog_pkg::*;
#(
  parameter int            CW       = CNT_W,
  parameter int            DW       = DATA_W,
  parameter int            AW       = ADDR_W,
  parameter logic [DW-1:0] ID_VALUE = 32'h0A57_1D01
) (
  input  logic          clk,
  input  logic          porN,
  input  logic          rstN,
  input  logic          busSelRefresh,
  input  logic          busSelControl,
  input  logic          busEnable,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic [DW-1:0] offsetReg,
  input  logic [CW-1:0] compareReg,
  input  logic          hit,
  output strobe_t       strb,
  output logic          ws0,
  output logic          ws1,
  output logic [DW-1:0] busRdata
);
  logic enable, wrCycle, wrCsr, wrOff, wrKick, refresh, expire;

  assign wrCycle = busEnable & busWrite;
  assign wrKick  = wrCycle & busSelRefresh & (busAddr == A_CSR);
  assign wrCsr   = wrCycle & busSelControl & (busAddr == A_CSR);
  assign wrOff   = wrCycle & busSelControl & (busAddr == A_OFFSET);
  assign refresh = wrKick | wrCsr | (wrOff & enable);
  assign expire  = enable & hit & ~refresh;

  assign strb.refresh    = refresh;
  assign strb.loadOffset = wrOff;
  assign strb.reload     = expire & ~ws0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      ws0    <= 1'b0;
    end else begin
      if (wrCsr) enable <= busWdata[0];
      if (refresh)     ws0 <= 1'b0;
      else if (expire) ws0 <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                ws1 <= 1'b0;
    else if (refresh)         ws1 <= 1'b0;
    else if (expire && ws0)   ws1 <= 1'b1;
  end

  always_comb begin
    busRdata = '0;
    if (busSelControl) begin
      case (busAddr)
        A_CSR:    busRdata = {{(DW-3){1'b0}}, ws1, ws0, enable};
        A_OFFSET: busRdata = offsetReg;
        A_CMP_LO: busRdata = compareReg[DW-1:0];
        A_CMP_HI: busRdata = compareReg[CW-1:CW-DW];
        A_IDENT:  busRdata = ID_VALUE;
        default:  busRdata = '0;
      endcase
    end else if (busSelRefresh) begin
      if (busAddr == A_IDENT) busRdata = ID_VALUE;
    end
  end

  assert_stage2_after_stage1_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ws1) |-> ws0);

  assert_stage2_sticky_R6: assert property (@(posedge clk) disable iff (!porN)
    ws1 && !refresh |=> ws1);

  assert_no_expiry_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ws0) |-> $past(enable));

  assert_refresh_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    refresh |=> !ws0 && !ws1);
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import twostage_wdog_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h0A57_1D01
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        warmRstN,
  input  logic [63:0] sysCount,
  input  logic        busSelRefresh,
  input  logic        busSelControl,
  input  logic        busEnable,
  input  logic        busWrite,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        alertOut,
  output logic        resetOut
);
  strobe_t            strb;
  logic               coreRstN, hit, ws0, ws1;
  logic [DATA_W-1:0]  offsetReg;
  logic [CNT_W-1:0]   compareReg;

  assign coreRstN = porN & warmRstN;
  assign alertOut = ws0;
  assign resetOut = ws1;

  twostage_wdog_ctrl #(.ID_VALUE(ID_VALUE)) u_ctrl (
    .clk(clk), .porN(porN), .rstN(coreRstN),
    .busSelRefresh(busSelRefresh), .busSelControl(busSelControl),
    .busEnable(busEnable), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .offsetReg(offsetReg), .compareReg(compareReg),
    .hit(hit), .strb(strb), .ws0(ws0), .ws1(ws1), .busRdata(busRdata)
  );

  twostage_wdog_dpath u_dpath (
    .clk(clk), .rstN(coreRstN), .sysCount(sysCount), .wdata(busWdata),
    .strb(strb), .offsetReg(offsetReg), .compareReg(compareReg), .hit(hit)
  );
endmodule

// File: tb/twostage_wdog_tb.sv
module twostage_wdog_tb;
  localparam logic [31:0] IDV = 32'h0A57_1D01;

  logic        clk = 1'b0;
  logic        porN, warmRstN;
  logic [63:0] sysCount;
  logic        busSelRefresh, busSelControl, busEnable, busWrite;
  logic [11:0] busAddr;
  logic [31:0] busWdata, busRdata;
  logic        alertOut, resetOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  twostage_wdog #(.ID_VALUE(IDV)) u_dut (
    .clk(clk), .porN(porN), .warmRstN(warmRstN), .sysCount(sysCount),
    .busSelRefresh(busSelRefresh), .busSelControl(busSelControl),
    .busEnable(busEnable), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .alertOut(alertOut), .resetOut(resetOut)
  );

  typedef struct packed {
    logic        wr;
    logic        ctrlFrame;
    logic [11:0] addr;
    logic [31:0] data;
    logic [63:0] cnt;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 12'h008, 32'd50,     64'd100,  32'd0},   // R4 offset while disabled
    '{1'b0, 1'b1, 12'h008, 32'd0,      64'd100,  32'd50},  // R4
    '{1'b0, 1'b1, 12'h010, 32'd0,      64'd100,  32'd0},   // R4 no refresh disabled
    '{1'b1, 1'b1, 12'h000, 32'd1,      64'd200,  32'd0},   // R3 enable
    '{1'b0, 1'b1, 12'h010, 32'd0,      64'd210,  32'd250}, // R3/R8
    '{1'b0, 1'b1, 12'h000, 32'd0,      64'd249,  32'd1},   // R5 one before
    '{1'b0, 1'b1, 12'h000, 32'd0,      64'd250,  32'd3},   // R5 equal
    '{1'b0, 1'b1, 12'h010, 32'd0,      64'd260,  32'd300}, // R5 reload
    '{1'b0, 1'b1, 12'h000, 32'd0,      64'd300,  32'd7},   // R6
    '{1'b0, 1'b1, 12'h014, 32'd0,      64'd300,  32'd0},   // R8 high word
    '{1'b1, 1'b0, 12'h000, 32'hDEAD,   64'd400,  32'd0},   // R2 kick
    '{1'b0, 1'b1, 12'h000, 32'd0,      64'd400,  32'd1},   // R2
    '{1'b0, 1'b1, 12'h010, 32'd0,      64'd400,  32'd450}, // R2
    '{1'b1, 1'b1, 12'h008, 32'd20,     64'd420,  32'd0},   // R4 enabled
    '{1'b0, 1'b1, 12'h010, 32'd0,      64'd420,  32'd440}, // R4
    '{1'b1, 1'b1, 12'h000, 32'd0,      64'd430,  32'd0},   // R3 disable
    '{1'b0, 1'b1, 12'h000, 32'd0,      64'd1000, 32'd0},   // R7
    '{1'b0, 1'b1, 12'h010, 32'd0,      64'd1000, 32'd450}, // R7
    '{1'b1, 1'b1, 12'h000, 32'd6,      64'd1000, 32'd0},   // R3 flag bits
    '{1'b0, 1'b1, 12'h000, 32'd0,      64'd1000, 32'd0},   // R3
    '{1'b0, 1'b1, 12'hFCC, 32'd0,      64'd1000, IDV},     // R9
    '{1'b0, 1'b0, 12'hFCC, 32'd0,      64'd1000, IDV},     // R9
    '{1'b0, 1'b1, 12'h020, 32'd0,      64'd1000, 32'd0},   // R11
    '{1'b0, 1'b0, 12'h000, 32'd0,      64'd1000, 32'd0}    // R11
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busIdle();
    busSelRefresh = 1'b0; busSelControl = 1'b0; busEnable = 1'b0;
    busWrite = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic peek(input logic ctrlFrame, input logic [11:0] a, output logic [31:0] d);
    busSelControl = ctrlFrame; busSelRefresh = ~ctrlFrame;
    busEnable = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busIdle();
  endtask

  task automatic poke(input logic ctrlFrame, input logic [11:0] a, input logic [31:0] d);
    busSelControl = ctrlFrame; busSelRefresh = ~ctrlFrame;
    busEnable = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busIdle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    porN = 1'b0; warmRstN = 1'b1; sysCount = '0;
    busIdle();
    repeat (3) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(1'b1, 12'h000, rd); check("R1 status", rd, 0);
    peek(1'b1, 12'h008, rd); check("R1 offset", rd, 0);
    peek(1'b1, 12'h010, rd); check("R1 deadline", rd, 0);
    check("R1 alertOut", alertOut, 0);
    check("R1 resetOut", resetOut, 0);

    for (int i = 0; i < NV; i++) begin
      sysCount      = VECS[i].cnt;
      busSelControl = VECS[i].ctrlFrame;
      busSelRefresh = ~VECS[i].ctrlFrame;
      busEnable     = 1'b1;
      busWrite      = VECS[i].wr;
      busAddr       = VECS[i].addr;
      busWdata      = VECS[i].data;
      @(negedge clk);
      if (!VECS[i].wr) check($sformatf("vector %0d", i), busRdata, VECS[i].exp);
    end
    busIdle();

    // R5/R6 directed: enable at 1000 with offset 20 -> deadline 1020
    poke(1'b1, 12'h000, 32'd1);
    peek(1'b1, 12'h010, rd); check("R3 deadline after enable", rd, 1020);
    sysCount = 64'd1019; @(negedge clk);
    check("R5 alert not early", alertOut, 0);
    sysCount = 64'd1020; @(negedge clk);
    check("R5 alertOut", alertOut, 1);
    check("R6 resetOut not yet", resetOut, 0);
    sysCount = 64'd1040; @(negedge clk);
    check("R6 resetOut", resetOut, 1);
    repeat (3) @(negedge clk);
    check("R6 resetOut held", resetOut, 1);

    // R10 warm reset keeps stage two
    warmRstN = 1'b0; @(negedge clk); warmRstN = 1'b1; @(negedge clk);
    peek(1'b1, 12'h000, rd); check("R10 status after warm", rd, 4);
    check("R10 resetOut kept", resetOut, 1);
    check("R10 alertOut cleared", alertOut, 0);
    peek(1'b1, 12'h008, rd); check("R10 offset cleared", rd, 0);
    porN = 1'b0; @(negedge clk); porN = 1'b1; @(negedge clk);
    peek(1'b1, 12'h000, rd); check("R10 status after por", rd, 0);
    check("R10 resetOut after por", resetOut, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule